// File: doc/BRIEF.md
# Power-Good Strap Latch Sequencer

This block runs the power-up sequence of a clock generator. A single input pin has two roles. Before the first power-good it is an active-low power-good input. While that power-good is asserted, the block captures the frequency-select and mode strap pins into holding registers. The block then waits through a settling delay and a lock delay, both counted in ticks of a timebase, and then enables the clock outputs. After that point the same pin is a live, active-high power-down request. Later toggles of the pin never re-capture the straps.

The shared pin and the strap pins each pass through a two-flop synchroniser. Strap bit 0 is frequency select A, bit 1 is frequency select B, bit 2 is frequency select C or test select, and bit 3 is the debug-port enable. During power-down, a mode input chooses between parking the outputs at a fixed level and floating them.

States are IDLE_PG (waiting for power-good), CAPTURE, SETTLE, LOCK_WAIT, RUN and PWR_DOWN. The transitions are:
- IDLE_PG→CAPTURE when the synchronised pin is low.
- CAPTURE→SETTLE unconditionally.
- SETTLE→LOCK_WAIT on the SETTLE_TICKS-th tick.
- LOCK_WAIT→RUN on the LOCK_TICKS-th tick.
- RUN→PWR_DOWN when the synchronised pin is high.
- PWR_DOWN→RUN when the synchronised pin is low.

Reset returns the block to IDLE_PG from any state.

Top module: `pg_strap_seq`

## Requirements
- R1: While reset is applied, and directly after it, `clk_oe`, `pd_active`, `out_hiz`, `out_park` and `strap_valid` are 0 and `strap_q` is all zeros.
- R2: Two clock edges after the pin is first seen low, the block enters CAPTURE. On the edge that leaves CAPTURE it loads `strap_q` with the strap pins delayed by two flops and sets `strap_valid` to 1.
- R3: While the pin stays high after reset, nothing is captured and `clk_oe` stays 0.
- R4: SETTLE lasts until SETTLE_TICKS ticks have been sampled on clock edges in that state.
- R5: LOCK_WAIT then lasts for LOCK_TICKS sampled ticks. `clk_oe` becomes 1 on the edge that samples the last of these ticks. The total is exactly SETTLE_TICKS+LOCK_TICKS ticks from capture to enable.
- R6: Once `strap_valid` is 1, `strap_q` never changes until reset, whatever the strap pins or the shared pin do.
- R7: Pin activity during SETTLE and LOCK_WAIT is ignored: it neither shortens nor extends the delays and does not cause power-down.
- R8: In RUN, a synchronised high on the pin enters PWR_DOWN, with `pd_active`=1 and `clk_oe`=0. A synchronised low returns the block to RUN.
- R9: In PWR_DOWN, `out_hiz` equals `hiz_sel` and `out_park` equals its inverse. Outside PWR_DOWN both are 0.
- R10: A reset in any state returns the block to IDLE_PG. The next power-good captures the straps present at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_pin | input | 1 | Shared pin: power-good (low) first, later power-down request (high) |
| strap_pins | input | STRAP_W | Raw strap inputs |
| tick | input | 1 | Timebase tick, one clock wide, synchronous |
| hiz_sel | input | 1 | Power-down mode: 1 float, 0 park |
| strap_q | output | STRAP_W | Captured strap values |
| strap_valid | output | 1 | Straps have been captured |
| clk_oe | output | 1 | Clock output enable |
| pd_active | output | 1 | Block is in power-down |
| out_hiz | output | 1 | Outputs to be floated |
| out_park | output | 1 | Outputs to be driven to a fixed level |

## Verification
The assertions assume that `tick` is synchronous to `clk` and that `hiz_sel` only changes away from the sampling edge. The stimulus drives every input, tick included, on the falling clock edge. The strap pins are assumed stable for at least two cycles before power-good, so the captured value is well defined. The bench changes straps only after capture, or well before the pin falls. The pin itself is random only during the delay states and during power-down pulses.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    typedef enum logic [2:0] {
        IDLE_PG   = 3'd0,
        CAPTURE   = 3'd1,
        SETTLE    = 3'd2,
        LOCK_WAIT = 3'd3,
        RUN       = 3'd4,
        PWR_DOWN  = 3'd5
    } seq_state_t;

    function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m < 2) ? 1 : $clog2(m);
    endfunction

endpackage

// File: rtl/pgs_sync.sv
module pgs_sync #(
    parameter int unsigned W       = 1,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= {W{RST_VAL}};
            q    <= {W{RST_VAL}};
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pgs_tick_timer.sv
module pgs_tick_timer #(
    parameter int unsigned SETTLE_TICKS = 26,
    parameter int unsigned LOCK_TICKS   = 180
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_settle,
    input  logic run_lock,
    input  logic tick,
    output logic done
);
    localparam int unsigned CNT_W = pgs_pkg::cnt_width(SETTLE_TICKS, LOCK_TICKS);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_TICKS - 1);
    localparam logic [CNT_W-1:0] LOCK_LAST   = CNT_W'(LOCK_TICKS - 1);

    logic [CNT_W-1:0] cnt;
    logic             active;
    logic             at_last;

    assign active  = run_settle | run_lock;
    assign at_last = (run_settle && cnt == SETTLE_LAST) || (run_lock && cnt == LOCK_LAST);
    assign done    = tick & at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!active) begin
            cnt <= '0;
        end else if (tick) begin
            if (at_last) cnt <= '0;
            else         cnt <= cnt + 1'b1;
        end
    end

    // R4/R5: the counter never passes the limit of the window it serves
    a_r4_settle_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run_settle |-> cnt <= SETTLE_LAST);
    a_r5_lock_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run_lock |-> cnt <= LOCK_LAST);
endmodule

// File: rtl/pgs_fsm.sv
module pgs_fsm
    import pgs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_s,
    input  logic       timer_done,
    input  logic       hiz_sel,
    output seq_state_t state,
    output logic       capture,
    output logic       run_settle,
    output logic       run_lock,
    output logic       clk_oe,
    output logic       pd_active,
    output logic       out_hiz,
    output logic       out_park
);
    seq_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IDLE_PG;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            IDLE_PG:   if (!pin_s)     nxt = CAPTURE;
            CAPTURE:                   nxt = SETTLE;
            SETTLE:    if (timer_done) nxt = LOCK_WAIT;
            LOCK_WAIT: if (timer_done) nxt = RUN;
            RUN:       if (pin_s)      nxt = PWR_DOWN;
            PWR_DOWN:  if (!pin_s)     nxt = RUN;
            default:                   nxt = IDLE_PG;
        endcase
    end

    always_comb begin
        capture    = 1'b0;
        run_settle = 1'b0;
        run_lock   = 1'b0;
        clk_oe     = 1'b0;
        pd_active  = 1'b0;
        out_hiz    = 1'b0;
        out_park   = 1'b0;
        unique case (state)
            IDLE_PG:   ;
            CAPTURE:   capture    = 1'b1;
            SETTLE:    run_settle = 1'b1;
            LOCK_WAIT: run_lock   = 1'b1;
            RUN:       clk_oe     = 1'b1;
            PWR_DOWN: begin
                pd_active = 1'b1;
                out_hiz   = hiz_sel;
                out_park  = ~hiz_sel;
            end
            default:   ;
        endcase
    end

    // R8: enable and power-down never overlap
    a_r8_oe_pd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(clk_oe && pd_active));
    // R4: the settle window closes only on a sampled tick
    a_r4_settle_exit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == LOCK_WAIT) |-> $past(timer_done));
    // R5: enable rises only from the lock wait or a power-down exit
    a_r5_oe_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_oe) |-> ($past(state) == LOCK_WAIT || $past(state) == PWR_DOWN));
    // R9: float and park are exclusive and only during power-down
    a_r9_mode_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_hiz && out_park) && ((out_hiz || out_park) == pd_active));
    // R7: power-down is reached only from RUN
    a_r7_pd_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_active) |-> $past(state) == RUN);
endmodule

// File: rtl/pg_strap_seq.sv
module pg_strap_seq
    import pgs_pkg::*;
#(
    parameter int unsigned STRAP_W      = 4,
    parameter int unsigned SETTLE_TICKS = 26,
    parameter int unsigned LOCK_TICKS   = 180
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pg_pin,
    input  logic [STRAP_W-1:0] strap_pins,
    input  logic               tick,
    input  logic               hiz_sel,
    output logic [STRAP_W-1:0] strap_q,
    output logic               strap_valid,
    output logic               clk_oe,
    output logic               pd_active,
    output logic               out_hiz,
    output logic               out_park
);
    logic               pin_s;
    logic [STRAP_W-1:0] straps_s;
    logic               timer_done;
    logic               capture;
    logic               run_settle;
    logic               run_lock;
    seq_state_t         state;

    pgs_sync #(.W(1), .RST_VAL(1'b1)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(pg_pin), .q(pin_s)
    );

    pgs_sync #(.W(STRAP_W), .RST_VAL(1'b0)) u_strap_sync (
        .clk(clk), .rst_n(rst_n), .d(strap_pins), .q(straps_s)
    );

    pgs_tick_timer #(.SETTLE_TICKS(SETTLE_TICKS), .LOCK_TICKS(LOCK_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .run_settle(run_settle), .run_lock(run_lock),
        .tick(tick), .done(timer_done)
    );

    pgs_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .timer_done(timer_done),
        .hiz_sel(hiz_sel), .state(state), .capture(capture),
        .run_settle(run_settle), .run_lock(run_lock), .clk_oe(clk_oe),
        .pd_active(pd_active), .out_hiz(out_hiz), .out_park(out_park)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_q     <= '0;
            strap_valid <= 1'b0;
        end else if (capture && !strap_valid) begin
            strap_q     <= straps_s;
            strap_valid <= 1'b1;
        end
    end

    // R6: captured straps hold until reset
    a_r6_straps_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(strap_valid) |-> ($stable(strap_q) && strap_valid));
    // R2: outputs are never enabled without captured straps
    a_r2_valid_before_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_oe || pd_active) |-> strap_valid);
    // R3: nothing leaves IDLE_PG while the synchronised pin is high
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == IDLE_PG && pin_s) |=> state == IDLE_PG);
endmodule

// File: tb/pg_strap_seq_bench.sv
module pg_strap_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 4;
    localparam int ST = 26;
    localparam int LT = 180;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pg_pin = 1'b1;
    logic [SW-1:0] strap_pins = '0;
    logic tick = 1'b0;
    logic hiz_sel = 1'b0;
    logic [SW-1:0] strap_q;
    logic strap_valid, clk_oe, pd_active, out_hiz, out_park;

    int checks = 0;
    int fails = 0;
    bit done_flag = 0;
    bit tick_en = 0;
    bit cmp_en = 0;
    int tick_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pg_strap_seq #(.STRAP_W(SW), .SETTLE_TICKS(ST), .LOCK_TICKS(LT)) u_pg_strap_seq (
        .clk(clk), .rst_n(rst_n), .pg_pin(pg_pin), .strap_pins(strap_pins),
        .tick(tick), .hiz_sel(hiz_sel), .strap_q(strap_q), .strap_valid(strap_valid),
        .clk_oe(clk_oe), .pd_active(pd_active), .out_hiz(out_hiz), .out_park(out_park)
    );

    // requirement-level reference model: 0 idle,1 capture,2 settle,3 lock,4 run,5 power-down
    logic m_p1, m_p2;
    logic [SW-1:0] m_s1, m_s2, m_straps;
    logic m_valid;
    int m_st, m_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_p1 <= 1'b1; m_p2 <= 1'b1; m_s1 <= '0; m_s2 <= '0;
            m_straps <= '0; m_valid <= 1'b0; m_st <= 0; m_cnt <= 0;
        end else begin
            m_p1 <= pg_pin; m_p2 <= m_p1; m_s1 <= strap_pins; m_s2 <= m_s1;
            if ((m_st == 2 || m_st == 3) && tick) tick_cnt = tick_cnt + 1;
            case (m_st)
                0: if (!m_p2) m_st <= 1;
                1: begin m_st <= 2; m_cnt <= 0; m_straps <= m_s2; m_valid <= 1'b1; end
                2: if (tick) begin
                       if (m_cnt == ST-1) begin m_st <= 3; m_cnt <= 0; end
                       else m_cnt <= m_cnt + 1;
                   end
                3: if (tick) begin
                       if (m_cnt == LT-1) begin m_st <= 4; m_cnt <= 0; end
                       else m_cnt <= m_cnt + 1;
                   end
                4: if (m_p2) m_st <= 5;
                default: if (!m_p2) m_st <= 4;
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && cmp_en) begin
            chk("R5 clk_oe vs model", {31'd0, clk_oe}, {31'd0, m_st == 4});
            chk("R8 pd_active vs model", {31'd0, pd_active}, {31'd0, m_st == 5});
            chk("R9 out_hiz vs model", {31'd0, out_hiz}, {31'd0, (m_st == 5) && hiz_sel});
            chk("R9 out_park vs model", {31'd0, out_park}, {31'd0, (m_st == 5) && !hiz_sel});
            chk("R2 strap_valid vs model", {31'd0, strap_valid}, {31'd0, m_valid});
            chk("R6 strap_q vs model", {{(32-SW){1'b0}}, strap_q}, {{(32-SW){1'b0}}, m_straps});
        end
    end

    always @(negedge clk) tick = tick_en && ($urandom % 3 == 0);

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic bring_up(input logic [SW-1:0] sv, input bit noisy);
        int guard;
        strap_pins = sv;
        cyc(4);
        tick_cnt = 0;
        pg_pin = 1'b0;
        guard = 0;
        while (m_st != 4 && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (noisy && (m_st == 2 || m_st == 3)) begin
                pg_pin = 1'($urandom % 2);
                strap_pins = SW'($urandom);
            end
        end
        pg_pin = 1'b0;
        #1;
        chk("R4 R5 ticks from capture to enable", tick_cnt, ST + LT);
        cyc(6);
        #1;
        chk("R7 enabled after noisy delay", {31'd0, clk_oe}, 32'd1);
        chk("R2 captured straps", {{(32-SW){1'b0}}, strap_q}, {{(32-SW){1'b0}}, sv});
        chk("R2 strap_valid set", {31'd0, strap_valid}, 32'd1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [SW-1:0] sv;
        cyc(3);
        #1;
        chk("R1 clk_oe in reset", {31'd0, clk_oe}, 32'd0);
        chk("R1 strap_valid in reset", {31'd0, strap_valid}, 32'd0);
        chk("R1 strap_q in reset", {{(32-SW){1'b0}}, strap_q}, 32'd0);
        rst_n = 1'b1;
        cmp_en = 1;
        tick_en = 1;
        cyc(1); #1;
        chk("R1 pd_active after reset", {31'd0, pd_active}, 32'd0);
        chk("R1 out_park after reset", {31'd0, out_park}, 32'd0);
        // R3: pin high, straps wiggle, ticks run
        for (int i = 0; i < 60; i++) begin
            strap_pins = SW'($urandom);
            cyc(1);
        end
        #1;
        chk("R3 no capture while pin high", {31'd0, strap_valid}, 32'd0);
        chk("R3 no enable while pin high", {31'd0, clk_oe}, 32'd0);

        bring_up(4'b1010, 1'b1);

        // R8 R9: power-down pulses with random mode
        for (int k = 0; k < 8; k++) begin
            hiz_sel = 1'($urandom);
            pg_pin = 1'b1;
            cyc(3 + int'($urandom % 10));
            #1;
            chk("R8 power-down entered", {31'd0, pd_active}, 32'd1);
            chk("R8 enable dropped", {31'd0, clk_oe}, 32'd0);
            chk("R9 float follows mode", {31'd0, out_hiz}, {31'd0, hiz_sel});
            hiz_sel = ~hiz_sel;
            #1;
            chk("R9 park follows mode", {31'd0, out_park}, {31'd0, ~hiz_sel});
            strap_pins = SW'($urandom);
            pg_pin = 1'b0;
            cyc(4);
            #1;
            chk("R8 back to run", {31'd0, clk_oe}, 32'd1);
            chk("R9 no float in run", {31'd0, out_hiz | out_park}, 32'd0);
            chk("R6 straps held", {{(32-SW){1'b0}}, strap_q}, 32'hA);
        end

        // R10: reset mid-power-down, then a fresh capture
        pg_pin = 1'b1;
        cyc(5);
        rst_n = 1'b0;
        #1;
        chk("R10 reset clears valid", {31'd0, strap_valid}, 32'd0);
        chk("R10 reset clears pd", {31'd0, pd_active}, 32'd0);
        cyc(2);
        rst_n = 1'b1;
        cyc(10); #1;
        chk("R10 idle after reset", {31'd0, clk_oe | strap_valid}, 32'd0);
        sv = 4'b0101;
        bring_up(sv, 1'b0);

        // R10: reset during settle, then random straps
        for (int r = 0; r < 3; r++) begin
            rst_n = 1'b0;
            pg_pin = 1'b1;
            cyc(2);
            rst_n = 1'b1;
            sv = SW'($urandom);
            strap_pins = sv;
            cyc(4);
            pg_pin = 1'b0;
            cyc(10 + int'($urandom % 20));
            #1;
            chk("R7 not enabled mid-delay", {31'd0, clk_oe}, 32'd0);
            chk("R10 new straps captured", {{(32-SW){1'b0}}, strap_q}, {{(32-SW){1'b0}}, sv});
        end
        pg_pin = 1'b1;
        cyc(5);
        cmp_en = 0;
        finish_run();
    end
endmodule